// File: doc/BRIEF.md
# Receive FIFO Packet-Available Flag Logic

This block is the receive half of a four-port PHY-side buffer that a bus master drains by polling. The line side writes bytes into a per-port queue. Each byte carries a start-of-packet mark and an end-of-packet mark. The master presents a port number on the poll lines and reads the answer on that port's bit of the available vector. It then asserts read enable with a port number and receives a byte together with its start and end strobes and a valid strobe.

The available flag of a port is set when the port's occupancy reaches a programmable low watermark, or when the port holds at least one complete packet end. The rule for clearing it depends on the transfer mode. In cell mode the flag stays up until the last byte of the cell in flight has been read, even when the queue runs dry. In packet mode the flag stays up through a packet in flight only while data remains, and it drops on the very cycle the queue empties, so the master can use it to qualify data. Poll answers and read data come back one or two clocks after the request. Both the latency and the transfer mode are taken from configuration pins during reset.

Top module: `rxq_avail_top`

## Requirements
- R1: The available vector has one bit per port, with port p on bit p. Only the bit of the polled port may be high, and with no poll in progress the vector returns to all zeros.
- R2: In one-cycle latency, a poll answer appears on the clock after the poll is sampled. A read enable sampled at an edge yields `rd_valid_o`, data, start and end strobes after that same edge, for exactly one cycle.
- R3: In two-cycle latency, both the poll answer and the read results appear one clock later than in R2. Nothing shows after the first edge.
- R4: A port's flag is high when its occupancy is nonzero and at or above the low watermark, or when at least one end-of-packet byte sits in its queue.
- R5: A low watermark of zero makes the flag equal to "queue not empty". The watermark is loaded through `lowmark_we`/`lowmark_in` while no traffic is in flight.
- R6: Cell mode (`cfg_pkt_mode`=0). After a byte without end mark has been read, the flag stays high until a byte with the end mark is read, even when occupancy is below the watermark or zero.
- R7: Packet mode (`cfg_pkt_mode`=1). With no transfer in flight, occupancy below the watermark and no end mark queued, the flag is low. During a transfer the flag holds while data remains and drops in the cycle the queue reaches zero.
- R8: Reading an end-marked byte removes it from the end-mark count. The flag then falls back to the watermark rule.
- R9: A read enable for an empty port is ignored. No valid, no start strobe, and no change of queue state.
- R10: Bytes leave a port in write order, each with the start and end marks it was written with.
- R11: `cfg_lat_two` and `cfg_pkt_mode` are captured only while `rst` is high. Changing them afterwards has no effect.
- R12: After reset, the available vector and `rd_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lat_two | input | 1 | 1 = two-cycle response latency (captured in reset) |
| cfg_pkt_mode | input | 1 | 1 = packet mode, 0 = cell mode (captured in reset) |
| lowmark_we | input | 1 | Load strobe for the low watermark |
| lowmark_in | input | CNT_W | Low watermark value in bytes |
| wr_en | input | 1 | Line-side write strobe |
| wr_port | input | PORT_W | Port written |
| wr_data | input | 8 | Byte written |
| wr_sop | input | 1 | Byte starts a packet |
| wr_eop | input | 1 | Byte ends a packet |
| poll_en | input | 1 | Poll request |
| poll_port | input | PORT_W | Port polled |
| rd_en | input | 1 | Read enable from the master |
| rd_port | input | PORT_W | Port read |
| avail_o | output | NPORTS | Per-port available answers |
| rd_valid_o | output | 1 | A byte is delivered |
| rd_data_o | output | 8 | Delivered byte |
| rd_sop_o | output | 1 | Delivered byte starts a packet |
| rd_eop_o | output | 1 | Delivered byte ends a packet |

## Verification
A table of fill patterns crosses occupancy just below, at and above the watermark, a zero watermark, a completely full queue and a queued end mark, in both modes. This separates the watermark term from the end-mark term. Directed sequences then drain a partly written unit byte by byte in each mode. Because the two modes differ only at the empty point, the sequence tells the cell-mode hold apart from the packet-mode drop. Separate poll and read sequences sample after the first and the second edge, which tells the two latency settings apart. A read of an empty port followed by a real read shows that no pointer moved.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BYTE_W-1:0] data;
    } rxq_word_t;

    typedef struct packed {
        logic      valid;
        rxq_word_t word;
    } rxq_out_t;

    localparam int OUT_W = $bits(rxq_out_t);

    function automatic logic flag_rule(input logic nonempty, input logic at_mark,
                                       input logic eop_held, input logic in_xfer,
                                       input logic pkt_mode);
        logic base;
        base = nonempty && (at_mark || eop_held);
        if (pkt_mode)
            return base || (in_xfer && nonempty);
        else
            return base || in_xfer;
    endfunction

endpackage

// File: rtl/rxq_port_q.sv
module rxq_port_q
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_mode,
    input  logic [CNT_W-1:0] lowmark,
    input  logic             push,
    input  rxq_word_t        push_word,
    input  logic             pop_req,
    output rxq_word_t        head_word,
    output logic             pop_fire,
    output logic             flag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxq_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] occ, eop_cnt;
    logic             mid;
    logic             full, empty, do_push;

    assign full      = (occ == CNT_W'(DEPTH));
    assign empty     = (occ == '0);
    assign do_push   = push && !full;
    assign pop_fire  = pop_req && !empty;
    assign head_word = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            occ     <= '0;
            eop_cnt <= '0;
            mid     <= 1'b0;
        end else begin
            if (do_push)  wptr <= bump(wptr);
            if (pop_fire) rptr <= bump(rptr);
            occ <= occ + CNT_W'(do_push) - CNT_W'(pop_fire);
            eop_cnt <= eop_cnt + CNT_W'(do_push && push_word.eop)
                               - CNT_W'(pop_fire && head_word.eop);
            if (pop_fire) mid <= !head_word.eop;
        end
    end

    assign flag = flag_rule(!empty, occ >= lowmark, eop_cnt != '0, mid, pkt_mode);

    assert_occ_bound_R4: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));
    assert_eop_le_occ_R8: assert property (@(posedge clk) disable iff (rst)
        eop_cnt <= occ);
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !push) |=> (occ == '0));
    assert_drain_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (pkt_mode && empty) |-> !flag);
    assert_cell_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!pkt_mode && mid) |-> flag);

endmodule

// File: rtl/rxq_lat_pipe.sv
module rxq_lat_pipe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         two,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    assign dout = two ? s2 : s1;
endmodule

// File: rtl/rxq_avail_top.sv
module rxq_avail_top
    import rxq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 16,
    parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_lat_two,
    input  logic              cfg_pkt_mode,
    input  logic              lowmark_we,
    input  logic [CNT_W-1:0]  lowmark_in,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              poll_en,
    input  logic [PORT_W-1:0] poll_port,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_port,
    output logic [NPORTS-1:0] avail_o,
    output logic              rd_valid_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_sop_o,
    output logic              rd_eop_o
);
    logic             lat_two_q, pkt_q;
    logic [CNT_W-1:0] lowmark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_two_q <= cfg_lat_two;
            pkt_q     <= cfg_pkt_mode;
            lowmark_q <= '0;
        end else if (lowmark_we) begin
            lowmark_q <= lowmark_in;
        end
    end

    rxq_word_t          in_word;
    rxq_word_t          heads [NPORTS];
    logic [NPORTS-1:0]  fires, flags, poll_hit;

    assign in_word = '{sop: wr_sop, eop: wr_eop, data: wr_data};

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        rxq_port_q #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_q (
            .clk       (clk),
            .rst       (rst),
            .pkt_mode  (pkt_q),
            .lowmark   (lowmark_q),
            .push      (wr_en && (wr_port == PORT_W'(i))),
            .push_word (in_word),
            .pop_req   (rd_en && (rd_port == PORT_W'(i))),
            .head_word (heads[i]),
            .pop_fire  (fires[i]),
            .flag      (flags[i])
        );
        assign poll_hit[i] = poll_en && (poll_port == PORT_W'(i)) && flags[i];
    end

    rxq_out_t rd_stage, rd_out;

    always_comb begin
        rd_stage = '0;
        if (|fires) begin
            rd_stage.valid = 1'b1;
            rd_stage.word  = heads[rd_port];
        end
    end

    rxq_lat_pipe #(.W(NPORTS)) u_poll_pipe (
        .clk (clk), .rst (rst), .two (lat_two_q), .din (poll_hit), .dout (avail_o)
    );

    rxq_lat_pipe #(.W(OUT_W)) u_rd_pipe (
        .clk (clk), .rst (rst), .two (lat_two_q), .din (rd_stage), .dout (rd_out)
    );

    assign rd_valid_o = rd_out.valid;
    assign rd_data_o  = rd_out.word.data;
    assign rd_sop_o   = rd_out.word.sop;
    assign rd_eop_o   = rd_out.word.eop;

    assert_poll_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(avail_o));
    assert_idle_poll_R2: assert property (@(posedge clk) disable iff (rst)
        (!lat_two_q && !poll_en) |=> (avail_o == '0));
    assert_valid_only_on_fire_R2: assert property (@(posedge clk) disable iff (rst)
        (!lat_two_q && !(|fires)) |=> !rd_valid_o);
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(lat_two_q) && $stable(pkt_q)));

endmodule

// File: tb/tb_rxq_avail_top.sv
`timescale 1ns/1ps
module tb_rxq_avail_top;
    localparam int NP = 4;
    localparam int DP = 16;
    localparam int CW = 5;

    logic       clk = 0, rst = 1;
    logic       cfg_lat_two = 0, cfg_pkt_mode = 1;
    logic       lowmark_we = 0;
    logic [CW-1:0] lowmark_in = '0;
    logic       wr_en = 0, wr_sop = 0, wr_eop = 0;
    logic [1:0] wr_port = '0, poll_port = '0, rd_port = '0;
    logic [7:0] wr_data = '0;
    logic       poll_en = 0, rd_en = 0;
    logic [NP-1:0] avail_o;
    logic       rd_valid_o, rd_sop_o, rd_eop_o;
    logic [7:0] rd_data_o;

    int n_tests = 0, n_fail = 0, cycles = 0;
    int lat = 1;
    logic [NP-1:0] got_av;
    logic       got_v, got_s, got_e;
    logic [7:0] got_d;

    rxq_avail_top #(.NPORTS(NP), .DEPTH(DP)) dut (
        .clk(clk), .rst(rst), .cfg_lat_two(cfg_lat_two), .cfg_pkt_mode(cfg_pkt_mode),
        .lowmark_we(lowmark_we), .lowmark_in(lowmark_in),
        .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .poll_en(poll_en), .poll_port(poll_port), .rd_en(rd_en), .rd_port(rd_port),
        .avail_o(avail_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .rd_sop_o(rd_sop_o), .rd_eop_o(rd_eop_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic two, input logic pkt);
        cfg_lat_two = two;
        cfg_pkt_mode = pkt;
        lat = two ? 2 : 1;
        rst = 1;
        cyc(); cyc();
        rst = 0;
    endtask

    task automatic set_mark(input int v);
        lowmark_in = CW'(v);
        lowmark_we = 1;
        cyc();
        lowmark_we = 0;
    endtask

    task automatic push(input int p, input int d, input logic s, input logic e);
        wr_en = 1; wr_port = 2'(p); wr_data = 8'(d); wr_sop = s; wr_eop = e;
        cyc();
        wr_en = 0; wr_sop = 0; wr_eop = 0;
    endtask

    task automatic poll(input int p);
        poll_en = 1; poll_port = 2'(p);
        cyc();
        poll_en = 0;
        if (lat == 2) cyc();
        got_av = avail_o;
    endtask

    task automatic pop(input int p);
        rd_en = 1; rd_port = 2'(p);
        cyc();
        rd_en = 0;
        if (lat == 2) cyc();
        got_v = rd_valid_o; got_s = rd_sop_o; got_e = rd_eop_o; got_d = rd_data_o;
    endtask

    localparam int NV = 9;
    localparam int V_PORT [NV] = '{0, 0, 1, 2, 2, 3, 3, 1, 0};
    localparam int V_N    [NV] = '{3, 4, 2, 0, 1, 16, 15, 7, 5};
    localparam int V_EOP  [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 1};
    localparam int V_MARK [NV] = '{4, 4, 8, 0, 0, 16, 16, 8, 8};
    localparam int V_PKT  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam int V_EXP  [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 1};

    initial begin
        do_reset(0, 1);
        cyc();
        check("R12 avail after reset", int'(avail_o), 0);
        check("R12 valid after reset", int'(rd_valid_o), 0);

        // R4 R5 R1 vector table
        for (int v = 0; v < NV; v++) begin
            do_reset(0, V_PKT[v][0]);
            set_mark(V_MARK[v]);
            for (int k = 0; k < V_N[v]; k++)
                push(V_PORT[v], k, k == 0, (V_EOP[v] != 0) && (k == V_N[v] - 1));
            poll(V_PORT[v]);
            check($sformatf("R4/R5 vector %0d", v), int'(got_av), V_EXP[v] << V_PORT[v]);
        end

        // R1: other port polled while port 0 is ready
        do_reset(0, 1);
        push(0, 8'h11, 1, 1);
        poll(2);
        check("R1 unpolled port", int'(got_av), 0);
        poll(0);
        check("R1 polled port bit", int'(got_av), 1);
        cyc();
        check("R1 idle vector", int'(avail_o), 0);

        // R2 R10 one-cycle read, order and marks
        push(0, 8'h22, 0, 0);
        pop(0);
        check("R2 valid", int'(got_v), 1);
        check("R10 first data", int'(got_d), 8'h11);
        check("R10 first sop", int'(got_s), 1);
        check("R10 first eop", int'(got_e), 1);
        cyc();
        check("R2 valid one cycle", int'(rd_valid_o), 0);
        pop(0);
        check("R10 second data", int'(got_d), 8'h22);
        check("R10 second sop", int'(got_s), 0);

        // R9 empty read ignored
        do_reset(0, 1);
        pop(3);
        check("R9 no valid", int'(got_v), 0);
        check("R9 no sop", int'(got_s), 0);
        push(3, 8'h77, 1, 0);
        pop(3);
        check("R9 pointer unchanged", int'(got_d), 8'h77);

        // R3 two-cycle latency
        do_reset(1, 1);
        set_mark(1);
        push(1, 8'h5A, 1, 0);
        poll_en = 1; poll_port = 2'd1;
        cyc();
        poll_en = 0;
        check("R3 poll not after one edge", int'(avail_o), 0);
        cyc();
        check("R3 poll after two edges", int'(avail_o), 2);
        rd_en = 1; rd_port = 2'd1;
        cyc();
        rd_en = 0;
        check("R3 read not after one edge", int'(rd_valid_o), 0);
        cyc();
        check("R3 read valid after two edges", int'(rd_valid_o), 1);
        check("R3 read data", int'(rd_data_o), 8'h5A);
        check("R3 read sop", int'(rd_sop_o), 1);

        // R8 end-mark count
        do_reset(0, 1);
        set_mark(8);
        push(2, 1, 1, 0);
        push(2, 2, 0, 1);
        poll(2);
        check("R8 eop present", int'(got_av), 4);
        pop(2); pop(2);
        push(2, 3, 1, 0);
        poll(2);
        check("R8 marker removed", int'(got_av), 0);

        // R6 R11 cell mode hold through empty queue
        do_reset(0, 0);
        cfg_pkt_mode = 1;
        set_mark(4);
        for (int k = 0; k < 4; k++) push(0, k, k == 0, 0);
        poll(0);
        check("R6 at mark", int'(got_av), 1);
        pop(0);
        poll(0);
        check("R6 hold below mark", int'(got_av), 1);
        pop(0); pop(0); pop(0);
        poll(0);
        check("R6 R11 hold when empty", int'(got_av), 1);
        push(0, 8'h99, 0, 1);
        pop(0);
        check("R10 eop strobe", int'(got_e), 1);
        poll(0);
        check("R6 drop after cell end", int'(got_av), 0);

        // R7 packet mode drop on drain
        do_reset(0, 1);
        set_mark(4);
        for (int k = 0; k < 4; k++) push(1, k, k == 0, 0);
        pop(1);
        poll(1);
        check("R7 hold in transfer", int'(got_av), 2);
        pop(1); pop(1); pop(1);
        poll(1);
        check("R7 drop on drain", int'(got_av), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule